// File: doc/BRIEF.md
# Prioritised Address Window Decoder

This block sits beside an external bus controller and decides, for every external access, which of five bus-configuration sets governs it. Four programmable address windows each own one configuration set; a fifth set (index 0) is the fallback for any address that no enabled window claims. When windows overlap, fixed priorities settle the choice. Windows 3 and 4 form one pair, windows 1 and 2 form the other. Inside each pair the higher-numbered window wins, and the 3/4 pair as a whole wins over the 1/2 pair. This gives the order 4, 3, 2, 1, then the default.

The decode is purely combinational from the access address and the stored registers. For the selected set, the block outputs the index, a one-hot chip-select vector and the timing and width fields. It also limits how many segment address lines (the address bits above the low 64 KB) are driven, according to a programmed address-space size. Software-visible configuration arrives through a simple write-only register port. Forming the bus cycle waveforms is left to the bus controller.

There is no state machine. The only sequential logic is the register file, and it has one implicit state per register: the reset value, or the last value written.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset all windows are disabled, every address selects configuration 0 (`cs_onehot` = 00001), all timing fields read 0, and the space-size code is 3 (all six segment lines driven).
- R2: Window k (select register at port address k-1, data layout: bits [9:0] start = address bits [21:12], bits [13:10] size code s, bit 15 enable) matches only when enabled and address bits [21:12+s] equal start bits [9:s]; size code s means a window of 4 KB × 2^s.
- R3: When windows 4 and 3 both match, configuration 4 is selected.
- R4: When windows 2 and 1 both match and neither 3 nor 4 does, configuration 2 is selected.
- R5: A match in window 3 or 4 is chosen over any match in window 1 or 2.
- R6: An address matched by no enabled window selects configuration 0.
- R7: The timing outputs follow the bus-control register of the selected configuration (port addresses 4..8 for configurations 0..4). The field layout is: bits [3:0] wait states, bit 4 tri-state extension, bit 5 long address-latch pulse, bit 6 read/write delay, bit 7 16-bit bus.
- R8: `cs_onehot` has exactly one bit set, at the position of the selected configuration index.
- R9: The space-size code (port address 9, bits [1:0]) of 0, 1, 2 or 3 drives 0, 2, 4 or 6 segment lines (64 KB, 256 KB, 1 MB, 4 MB). Lines that are not driven read 0 on `seg_out` and on `seg_drive`.
- R10: Size codes above 8 behave as code 8 (1 MB window).
- R11: Writes to port addresses 10 to 15 change no register.
- R12: A register write takes effect at the next rising clock edge. The address decode responds in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| acc_addr | input | 22 | External access address |
| cfg_sel | output | 3 | Selected configuration index 0..4 |
| cs_onehot | output | 5 | One-hot chip select per configuration |
| wait_states | output | 4 | Memory cycle wait states |
| tristate_ext | output | 1 | Tri-state time extension |
| ale_long | output | 1 | Long address-latch pulse |
| rw_delay | output | 1 | Read/write strobe delay |
| bus_16bit | output | 1 | 1 = 16-bit multiplexed bus, 0 = 8-bit |
| seg_out | output | 6 | Segment address lines, masked |
| seg_drive | output | 6 | Output enable per segment line |

## Verification
The bench builds the block with its default parameters: 22 address bits, segment lines from bit 16, a 4 KB granule and a largest size code of 8. These values make all six segment lines and every space-size code reachable, along with the full range of window sizes from 4 KB to 1 MB and the clamp of larger codes. Nested and overlapping windows are placed so that each pair's internal priority and the cross-pair order are exercised, including the edges of each window.

// File: rtl/awd_pkg.sv
package awd_pkg;

    // register port map
    localparam int REG_WIN_BASE = 0;
    localparam int REG_BC_BASE  = 4;
    localparam int REG_SPACE    = 9;

    // bus-control fields, packed so that bit 0 is wait_st[0]
    typedef struct packed {
        logic       bus16;
        logic       rw_dly;
        logic       ale_long;
        logic       tri_ext;
        logic [3:0] wait_st;
    } bus_cfg_t;

    localparam int BC_W = $bits(bus_cfg_t);

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int GRAN_LOG = 12,
    parameter int DATA_W   = 16,
    parameter int NUM_WIN  = 4,
    parameter int NUM_CFG  = NUM_WIN + 1,
    localparam int START_W = ADDR_W - GRAN_LOG
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [3:0]                        addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_WIN-1:0]                win_en,
    output logic [NUM_WIN-1:0][3:0]           win_size,
    output logic [NUM_WIN-1:0][START_W-1:0]   win_start,
    output bus_cfg_t [NUM_CFG-1:0]            cfg,
    output logic [1:0]                        space_code
);

    localparam int SIZE_LSB = START_W;

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    win_en[w]    <= 1'b0;
                    win_size[w]  <= '0;
                    win_start[w] <= '0;
                end else if (we && addr == 4'(REG_WIN_BASE + w)) begin
                    win_en[w]    <= wdata[DATA_W-1];
                    win_size[w]  <= wdata[SIZE_LSB+3:SIZE_LSB];
                    win_start[w] <= wdata[START_W-1:0];
                end
            end
        end
        for (w = 0; w < NUM_CFG; w++) begin : g_cfg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cfg[w] <= '0;
                else if (we && addr == 4'(REG_BC_BASE + w))
                    cfg[w] <= bus_cfg_t'(wdata[BC_W-1:0]);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            space_code <= 2'd3;
        else if (we && addr == 4'(REG_SPACE))
            space_code <= wdata[1:0];
    end

    // R12: a write lands at the next edge
    p_space_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'(REG_SPACE)) |=> space_code == $past(wdata[1:0]));
    p_bc0_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'(REG_BC_BASE)) |=> cfg[0] == $past(wdata[BC_W-1:0]));
    // R11: unmapped addresses leave every register alone
    p_unmapped_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > 4'(REG_SPACE)) |=>
            ($stable(space_code) && $stable(win_en) && $stable(win_start) && $stable(cfg)));

endmodule

// File: rtl/awd_window_match.sv
module awd_window_match #(
    parameter int ADDR_W        = 22,
    parameter int GRAN_LOG      = 12,
    parameter int MAX_SIZE_CODE = 8,
    localparam int START_W      = ADDR_W - GRAN_LOG
) (
    input  logic [START_W-1:0] addr_hi,
    input  logic               en,
    input  logic [3:0]         size_code,
    input  logic [START_W-1:0] start,
    output logic               hit
);

    logic [3:0]         size_eff;
    logic [START_W-1:0] cmp_mask;

    // codes past the largest size fold onto it
    assign size_eff = (size_code > 4'(MAX_SIZE_CODE)) ? 4'(MAX_SIZE_CODE) : size_code;

    genvar b;
    generate
        for (b = 0; b < START_W; b++) begin : g_mask
            assign cmp_mask[b] = (4'(b) >= size_eff);
        end
    endgenerate

    assign hit = en && (((addr_hi ^ start) & cmp_mask) == '0);

    always_comb begin
        if (!en) p_disabled_quiet_r2: assert (!hit);
        if (size_code > 4'(MAX_SIZE_CODE)) p_clamp_r10: assert (!cmp_mask[MAX_SIZE_CODE-1]);
    end

endmodule

// File: rtl/awd_resolve.sv
module awd_resolve #(
    parameter int NUM_WIN = 4,
    localparam int SEL_W  = $clog2(NUM_WIN + 1)
) (
    input  logic [NUM_WIN-1:0] hit,
    output logic [SEL_W-1:0]   sel
);

    // higher window index wins; pair 3/4 therefore beats pair 1/2
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_WIN; i++)
            if (hit[i]) sel = SEL_W'(i + 1);
    end

    always_comb begin
        if (hit[NUM_WIN-1]) p_top_wins_r3: assert (sel == SEL_W'(NUM_WIN));
        if (hit[1] && !hit[2] && !hit[3]) p_pair_low_r4: assert (sel == SEL_W'(2));
        if ((hit[2] || hit[3]) && (hit[0] || hit[1])) p_pair_order_r5: assert (sel >= SEL_W'(3));
        if (hit == '0) p_default_r6: assert (sel == '0);
    end

endmodule

// File: rtl/awd_seg_limit.sv
module awd_seg_limit #(
    parameter int SEG_W = 6
) (
    input  logic [SEG_W-1:0] seg_in,
    input  logic [1:0]       space_code,
    output logic [SEG_W-1:0] seg_out,
    output logic [SEG_W-1:0] seg_drive
);

    logic [3:0] line_cnt;
    assign line_cnt = {1'b0, space_code, 1'b0};

    genvar i;
    generate
        for (i = 0; i < SEG_W; i++) begin : g_line
            assign seg_drive[i] = (4'(i) < line_cnt);
            assign seg_out[i]   = seg_in[i] & seg_drive[i];
        end
    endgenerate

    always_comb begin
        if (32'(line_cnt) <= SEG_W)
            p_line_count_r9: assert ($countones(seg_drive) == 32'(line_cnt));
    end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int ADDR_W        = 22,
    parameter int SEG_BASE      = 16,
    parameter int GRAN_LOG      = 12,
    parameter int MAX_SIZE_CODE = 8,
    parameter int DATA_W        = 16,
    localparam int NUM_WIN      = 4,
    localparam int NUM_CFG      = NUM_WIN + 1,
    localparam int SEL_W        = $clog2(NUM_CFG),
    localparam int SEG_W        = ADDR_W - SEG_BASE,
    localparam int START_W      = ADDR_W - GRAN_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [SEL_W-1:0]  cfg_sel,
    output logic [NUM_CFG-1:0] cs_onehot,
    output logic [3:0]        wait_states,
    output logic              tristate_ext,
    output logic              ale_long,
    output logic              rw_delay,
    output logic              bus_16bit,
    output logic [SEG_W-1:0]  seg_out,
    output logic [SEG_W-1:0]  seg_drive
);

    logic [NUM_WIN-1:0]              win_en;
    logic [NUM_WIN-1:0][3:0]         win_size;
    logic [NUM_WIN-1:0][START_W-1:0] win_start;
    bus_cfg_t [NUM_CFG-1:0]          cfg;
    logic [1:0]                      space_code;
    logic [NUM_WIN-1:0]              hit;
    bus_cfg_t                        cur;
    logic                            unused_low;

    assign unused_low = ^acc_addr[GRAN_LOG-1:0] ^ ^reg_wdata[DATA_W-2:START_W+4];

    awd_regfile #(
        .ADDR_W(ADDR_W), .GRAN_LOG(GRAN_LOG), .DATA_W(DATA_W),
        .NUM_WIN(NUM_WIN), .NUM_CFG(NUM_CFG)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .win_en(win_en), .win_size(win_size), .win_start(win_start),
        .cfg(cfg), .space_code(space_code)
    );

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_match
            awd_window_match #(
                .ADDR_W(ADDR_W), .GRAN_LOG(GRAN_LOG), .MAX_SIZE_CODE(MAX_SIZE_CODE)
            ) i_match (
                .addr_hi(acc_addr[ADDR_W-1:GRAN_LOG]),
                .en(win_en[w]), .size_code(win_size[w]), .start(win_start[w]),
                .hit(hit[w])
            );
        end
        for (w = 0; w < NUM_CFG; w++) begin : g_cs
            assign cs_onehot[w] = (cfg_sel == SEL_W'(w));
        end
    endgenerate

    awd_resolve #(.NUM_WIN(NUM_WIN)) i_resolve (.hit(hit), .sel(cfg_sel));

    always_comb begin
        cur = cfg[0];
        for (int k = 1; k < NUM_CFG; k++)
            if (cfg_sel == SEL_W'(k)) cur = cfg[k];
    end

    assign wait_states  = cur.wait_st;
    assign tristate_ext = cur.tri_ext;
    assign ale_long     = cur.ale_long;
    assign rw_delay     = cur.rw_dly;
    assign bus_16bit    = cur.bus16;

    awd_seg_limit #(.SEG_W(SEG_W)) i_seg (
        .seg_in(acc_addr[ADDR_W-1:SEG_BASE]), .space_code(space_code),
        .seg_out(seg_out), .seg_drive(seg_drive)
    );

    always_comb begin
        p_cs_onehot_r8: assert ($onehot(cs_onehot));
    end

endmodule

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [21:0] acc_addr = '0;
    logic [2:0]  cfg_sel;
    logic [4:0]  cs_onehot;
    logic [3:0]  wait_states;
    logic        tristate_ext, ale_long, rw_delay, bus_16bit;
    logic [5:0]  seg_out, seg_drive;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .acc_addr(acc_addr), .cfg_sel(cfg_sel),
        .cs_onehot(cs_onehot), .wait_states(wait_states), .tristate_ext(tristate_ext),
        .ale_long(ale_long), .rw_delay(rw_delay), .bus_16bit(bus_16bit),
        .seg_out(seg_out), .seg_drive(seg_drive)
    );

    // bus-control words written for configurations 0..4
    localparam logic [15:0] BC [5] = '{16'h0082, 16'h0019, 16'h0024, 16'h00C7, 16'h00BF};

    // {address, expected configuration}
    localparam logic [24:0] VEC [14] = '{
        {22'h000000, 3'd1}, {22'h00FFFF, 3'd1}, {22'h010000, 3'd0},
        {22'h008000, 3'd2}, {22'h008FFF, 3'd2}, {22'h009000, 3'd1},
        {22'h100000, 3'd3}, {22'h103FFF, 3'd3}, {22'h104000, 3'd4},
        {22'h107FFF, 3'd4}, {22'h108000, 3'd3}, {22'h1FFFFF, 3'd3},
        {22'h200000, 3'd0}, {22'h3FFFFF, 3'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic probe(input logic [21:0] a, input logic [2:0] exp, input string req);
        acc_addr = a;
        #1;
        chk(req, 32'(cfg_sel), 32'(exp));
        chk("R8", 32'(cs_onehot), 32'(5'b1 << exp));
    endtask

    initial begin
        for (int n = 0; n < 5000; n++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        probe(22'h104000, 3'd0, "R1");
        chk("R1", 32'({wait_states, tristate_ext, ale_long, rw_delay, bus_16bit}), 32'd0);
        chk("R1", 32'(seg_drive), 32'h3F);

        for (int k = 0; k < 5; k++) wr(4'(4 + k), BC[k]);
        wr(4'd0, 16'h9000);   // W1 64 KB at 0
        wr(4'd1, 16'h8008);   // W2 4 KB at 0x008000
        wr(4'd2, 16'hA100);   // W3 1 MB at 0x100000
        wr(4'd3, 16'h8904);   // W4 16 KB at 0x104000

        // R2 R3 R4 R6 R7: vector walk
        for (int v = 0; v < 14; v++) begin
            logic [2:0] e;
            e = VEC[v][2:0];
            probe(VEC[v][24:3], e, "R2/R3/R4/R6");
            chk("R7", 32'({bus_16bit, rw_delay, ale_long, tristate_ext, wait_states}),
                32'(BC[e][7:0]));
        end

        // R2: disabled window ignored
        wr(4'd3, 16'h0904);
        probe(22'h104000, 3'd3, "R2");

        // R10: oversize code acts as 1 MB
        wr(4'd2, 16'hBD00);
        probe(22'h1FFFFF, 3'd3, "R10");
        probe(22'h200000, 3'd0, "R10");
        probe(22'h0FFFFF, 3'd0, "R10");

        // R5: window 3 over windows 1 and 2
        wr(4'd2, 16'h8000);
        probe(22'h000800, 3'd3, "R5");
        probe(22'h001000, 3'd1, "R5");
        wr(4'd2, 16'h8008);
        probe(22'h008000, 3'd3, "R5");

        // R11: unmapped writes
        wr(4'd12, 16'hFFFF);
        wr(4'd10, 16'h0000);
        probe(22'h3FFFFF, 3'd0, "R11");
        chk("R11", 32'(seg_drive), 32'h3F);
        chk("R11", 32'(wait_states), 32'(BC[0][3:0]));

        // R12: write visible only after the edge; decode same cycle
        wr(4'd2, 16'h0000);
        acc_addr = 22'h008000;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 16'h0008;
        #1;
        chk("R12", 32'(cfg_sel), 32'd2);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R12", 32'(cfg_sel), 32'd1);
        acc_addr = 22'h010000;
        #1;
        chk("R12", 32'(cfg_sel), 32'd0);

        // R9: segment line limit
        acc_addr = 22'h3FFFFF;
        for (int c = 0; c < 4; c++) begin
            logic [5:0] m;
            wr(4'd9, 16'(c));
            m = 6'((1 << (2 * c)) - 1);
            #1;
            chk("R9", 32'(seg_drive), 32'(m));
            chk("R9", 32'(seg_out), 32'(m));
        end
        acc_addr = 22'h2A0000;
        #1;
        chk("R9", 32'(seg_out), 32'h2A);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule